// File: doc/BRIEF.md
# CAN Bit Timing Synchronizer

This block divides each CAN bit into time quanta and keeps that division aligned with the traffic on the bus. A bit is one synchronization quantum, then a first phase segment and then a second phase segment. Both phase segment lengths and the jump width are programmed as the number of quanta minus one. A single-cycle tick from an external prescaler advances the block by one quantum. At the boundary between the two phase segments the block takes the bit value. It raises a transmit-point strobe during the synchronization quantum, where the transmitter may change its output.

The receive line passes through a two-flop synchronizer. A falling edge (recessive to dominant) is detected by comparing the line at two consecutive ticks. While the bus is idle, such an edge forces a hard restart of the bit. During a frame, each edge is given a signed phase error. The block either restarts the bit, stretches the first phase segment, or cuts the second phase segment short, and the jump width limits each correction. A combinational checker flags programmed values that cannot work with the selected sample mode and the propagation delay parameter.

Top module: `canbt_sync`

## Requirements
- R1: After reset the transmit-point strobe is 1 (the bit starts in its synchronization quantum), the sample strobe is 0, the sampled bit is 1 (recessive) and the phase error output is 0.
- R2: With no correction a bit lasts 1 + (seg1+1) + (seg2+1) quanta. The sample strobe rises at the tick that ends the last first-segment quantum and stays high until the next tick. In single-sample mode the sampled bit is the line value at that tick. The transmit-point strobe is high exactly while the synchronization quantum is current.
- R3: A falling edge seen at a tick while busIdle is 1 makes the quantum that just ended the synchronization quantum. The next quantum is the first of the first segment, and the phase error output becomes 0.
- R4: The phase error of an edge is measured at the tick that ends the quantum in which the edge occurred. It is 0 in the synchronization quantum, +k in the k-th first-segment quantum (counting from 1), and minus the number of second-segment quanta from that one to the segment end, both included. Each accepted edge loads this value onto phErr as a two's complement value.
- R5: During a frame, an edge whose phase error magnitude is at most sjw+1 restarts the bit exactly as in R3.
- R6: An edge with phase error greater than sjw+1 lengthens the first segment of the current bit by sjw+1 quanta, which delays the sample strobe.
- R7: An edge with phase error less than -(sjw+1) shortens the second segment of the current bit by sjw+1 quanta. When that leaves no quanta, the next quantum is the synchronization quantum.
- R8: During a frame, only the first edge in a bit is acted on. Later edges in the same bit change neither phErr nor the segment timing.
- R9: While txDom is 1 (the block's own transmitter is driving dominant), edges during a frame are ignored.
- R10: With threeSmp at 1, the sampled bit is the majority of the line values at the ticks that end the last three first-segment quanta.
- R11: cfgErr is 1 exactly when seg2+1 < 2, or seg2+1 < sjw+1, or seg1+1 < (sjw+1) + PROP_TQ + threeSmp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| tqTick | input | 1 | One-cycle pulse that ends the current time quantum |
| rxIn | input | 1 | Receive line, 1 = recessive |
| busIdle | input | 1 | Bus idle, so the next falling edge is a frame start |
| txDom | input | 1 | Own transmitter drives dominant; blocks resynchronization |
| threeSmp | input | 1 | 1 = three-sample majority mode |
| tseg1 | input | 4 | First phase segment length minus one |
| tseg2 | input | 3 | Second phase segment length minus one |
| sjw | input | 2 | Jump width minus one |
| sampleStb | output | 1 | Sample point strobe, one quantum long |
| sampledBit | output | 1 | Bit value taken at the last sample point |
| txPt | output | 1 | High during the synchronization quantum |
| phErr | output | 8 | Signed phase error of the last accepted edge |
| cfgErr | output | 1 | Programmed timing is invalid |

## Verification
The bench uses the default widths: a four-bit first segment, a three-bit second segment, a two-bit jump width, one quantum of propagation delay and two synchronizer stages. Most timing runs use seg1=5, seg2=2 and sjw=1, which gives a ten-quantum bit with a jump width of two. At these values, edges at +2, +4, +5, +6 and -3 quanta land on each side of the jump width, and sample and transmit points can be counted tick by tick. The configuration table also drives every field to its maximum, and it includes three-sample settings that sit exactly on the minimum segment length and one quantum below it.

// File: rtl/canbt_pkg.sv
package canbt_pkg;
  localparam int ERR_W = 8;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_ONE  = 2'd1,
    SEG_TWO  = 2'd2
  } segT;

  typedef struct packed {
    logic                    sampleNow;
    logic                    errLoad;
    logic signed [ERR_W-1:0] errVal;
  } ctlStrobeT;
endpackage

// File: rtl/canbt_ctrl.sv
module canbt_ctrl
  import canbt_pkg::*;
#(
  parameter int T1W   = 4,
  parameter int T2W   = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tqTick,
  input  logic             edgeTick,
  input  logic             busIdle,
  input  logic             txDom,
  input  logic [T1W-1:0]   tseg1,
  input  logic [T2W-1:0]   tseg2,
  input  logic [SJW_W-1:0] sjw,
  output ctlStrobeT        strb,
  output logic             txPt
);
  localparam int CW = T1W + 2;

  segT                     seg;
  logic [CW-1:0]           cnt, cntInc, ext, shrt, extN, shrtN;
  logic [CW-1:0]           sjwQ, seg1Len, seg2Full, seg2Len;
  logic                    syncDone;
  logic signed [ERR_W-1:0] phase, sjwS;
  logic                    accept, hardSync, posBig, negBig, seg1End, seg2End;

  always_comb begin
    sjwQ     = CW'(sjw) + CW'(1);
    seg2Full = CW'(tseg2) + CW'(1);
    cntInc   = cnt + CW'(1);
    case (seg)
      SEG_ONE: phase = $signed(ERR_W'(cntInc));
      SEG_TWO: phase = -$signed(ERR_W'(seg2Full - cnt));
      default: phase = '0;
    endcase
    sjwS     = $signed(ERR_W'(sjwQ));
    accept   = tqTick && edgeTick && (busIdle || (!syncDone && !txDom));
    posBig   = phase > sjwS;
    negBig   = phase < -sjwS;
    hardSync = accept && (busIdle || (!posBig && !negBig));
    extN     = (accept && !hardSync && posBig) ? sjwQ : ext;
    shrtN    = (accept && !hardSync && negBig) ? sjwQ : shrt;
    seg1Len  = CW'(tseg1) + CW'(1) + extN;
    seg2Len  = seg2Full - shrtN;
    seg1End  = (seg == SEG_ONE) && (cntInc >= seg1Len);
    seg2End  = (seg == SEG_TWO) && (cntInc >= seg2Len);
    strb.sampleNow = tqTick && !hardSync && seg1End;
    strb.errLoad   = accept;
    strb.errVal    = busIdle ? '0 : phase;
    txPt           = (seg == SEG_SYNC);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      seg      <= SEG_SYNC;
      cnt      <= '0;
      ext      <= '0;
      shrt     <= '0;
      syncDone <= 1'b0;
    end else if (tqTick) begin
      if (hardSync) begin
        seg      <= SEG_ONE;
        cnt      <= '0;
        ext      <= '0;
        shrt     <= '0;
        syncDone <= 1'b1;
      end else begin
        ext  <= extN;
        shrt <= shrtN;
        if (accept) syncDone <= 1'b1;
        case (seg)
          SEG_SYNC: begin
            seg <= SEG_ONE;
            cnt <= '0;
          end
          SEG_ONE: begin
            if (seg1End) begin
              seg <= SEG_TWO;
              cnt <= '0;
            end else begin
              cnt <= cntInc;
            end
          end
          SEG_TWO: begin
            if (seg2End) begin
              seg      <= SEG_SYNC;
              cnt      <= '0;
              ext      <= '0;
              shrt     <= '0;
              syncDone <= 1'b0;
            end else begin
              cnt <= cntInc;
            end
          end
          default: begin
            seg <= SEG_SYNC;
            cnt <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/canbt_dp.sv
module canbt_dp
  import canbt_pkg::*;
#(
  parameter int T1W         = 4,
  parameter int T2W         = 3,
  parameter int SJW_W       = 2,
  parameter int PROP_TQ     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tqTick,
  input  logic                    rxIn,
  input  logic                    threeSmp,
  input  logic [T1W-1:0]          tseg1,
  input  logic [T2W-1:0]          tseg2,
  input  logic [SJW_W-1:0]        sjw,
  input  ctlStrobeT               strb,
  output logic                    edgeTick,
  output logic                    sampleStb,
  output logic                    sampledBit,
  output logic signed [ERR_W-1:0] phErr,
  output logic                    cfgErr
);
  localparam int QW = T1W + 2;

  logic [SYNC_STAGES-1:0] rxPipe;
  logic                   rxS, prevRx, maj;
  logic [1:0]             hist;
  logic [QW-1:0]          q1, q2, sq, minS1;

  assign rxS      = rxPipe[SYNC_STAGES-1];
  assign edgeTick = prevRx && !rxS;
  assign maj      = (hist[1] & hist[0]) | (hist[1] & rxS) | (hist[0] & rxS);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) rxPipe <= '1;
    else     rxPipe <= {rxPipe[SYNC_STAGES-2:0], rxIn};
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prevRx     <= 1'b1;
      hist       <= 2'b11;
      sampleStb  <= 1'b0;
      sampledBit <= 1'b1;
      phErr      <= '0;
    end else if (tqTick) begin
      prevRx    <= rxS;
      hist      <= {hist[0], rxS};
      sampleStb <= strb.sampleNow;
      if (strb.sampleNow) sampledBit <= threeSmp ? maj : rxS;
      if (strb.errLoad)   phErr      <= strb.errVal;
    end
  end

  always_comb begin
    q1     = QW'(tseg1) + QW'(1);
    q2     = QW'(tseg2) + QW'(1);
    sq     = QW'(sjw) + QW'(1);
    minS1  = sq + QW'(PROP_TQ) + QW'(threeSmp);
    cfgErr = (q2 < QW'(2)) || (q2 < sq) || (q1 < minS1);
  end
endmodule

// File: rtl/canbt_sync.sv
module canbt_sync
  import canbt_pkg::*;
#(
  parameter int T1W         = 4,
  parameter int T2W         = 3,
  parameter int SJW_W       = 2,
  parameter int PROP_TQ     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tqTick,
  input  logic                    rxIn,
  input  logic                    busIdle,
  input  logic                    txDom,
  input  logic                    threeSmp,
  input  logic [T1W-1:0]          tseg1,
  input  logic [T2W-1:0]          tseg2,
  input  logic [SJW_W-1:0]        sjw,
  output logic                    sampleStb,
  output logic                    sampledBit,
  output logic                    txPt,
  output logic signed [ERR_W-1:0] phErr,
  output logic                    cfgErr
);
  ctlStrobeT strb;
  logic      edgeTick;

  canbt_ctrl #(.T1W(T1W), .T2W(T2W), .SJW_W(SJW_W)) ctrl_i (
    .clk(clk), .rst(rst), .tqTick(tqTick), .edgeTick(edgeTick),
    .busIdle(busIdle), .txDom(txDom), .tseg1(tseg1), .tseg2(tseg2),
    .sjw(sjw), .strb(strb), .txPt(txPt)
  );

  canbt_dp #(.T1W(T1W), .T2W(T2W), .SJW_W(SJW_W), .PROP_TQ(PROP_TQ),
             .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rst(rst), .tqTick(tqTick), .rxIn(rxIn),
    .threeSmp(threeSmp), .tseg1(tseg1), .tseg2(tseg2), .sjw(sjw),
    .strb(strb), .edgeTick(edgeTick), .sampleStb(sampleStb),
    .sampledBit(sampledBit), .phErr(phErr), .cfgErr(cfgErr)
  );
endmodule

// File: rtl/canbt_sync_chk.sv
module canbt_sync_chk
  import canbt_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic                    tqTick,
  input logic                    busIdle,
  input logic                    edgeTick,
  input logic                    sampleStb,
  input logic                    sampledBit,
  input logic                    txPt,
  input logic signed [ERR_W-1:0] phErr
);
  AST_SAMPLE_ONE_TQ: assert property (@(posedge clk) disable iff (rst)
    tqTick && sampleStb |=> !sampleStb); // R2
  AST_OUTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tqTick |=> $stable(sampleStb) && $stable(sampledBit) && $stable(txPt)); // R2
  AST_NO_SAMPLE_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
    txPt |-> !sampleStb); // R2
  AST_HARD_SYNC_SEG1: assert property (@(posedge clk) disable iff (rst)
    tqTick && edgeTick && busIdle |=> !txPt && !sampleStb && (phErr == '0)); // R3
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tqTick |=> $stable(phErr)); // R4
endmodule

bind canbt_sync canbt_sync_chk chk_i (
  .clk(clk), .rst(rst), .tqTick(tqTick), .busIdle(busIdle),
  .edgeTick(edgeTick), .sampleStb(sampleStb), .sampledBit(sampledBit),
  .txPt(txPt), .phErr(phErr)
);

// File: tb/canbt_sync_tb_top.sv
module canbt_sync_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tqTick = 1'b0, rxIn = 1'b1, busIdle = 1'b0, txDom = 1'b0, threeSmp = 1'b0;
  logic [3:0] tseg1 = 4'd5;
  logic [2:0] tseg2 = 3'd2;
  logic [1:0] sjw = 2'd1;
  logic sampleStb, sampledBit, txPt, cfgErr;
  logic signed [7:0] phErr;
  int nChecks = 0;
  int nErr = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  canbt_sync dut_i (
    .clk(clk), .rst(rst), .tqTick(tqTick), .rxIn(rxIn), .busIdle(busIdle),
    .txDom(txDom), .threeSmp(threeSmp), .tseg1(tseg1), .tseg2(tseg2),
    .sjw(sjw), .sampleStb(sampleStb), .sampledBit(sampledBit), .txPt(txPt),
    .phErr(phErr), .cfgErr(cfgErr)
  );

  // {tseg1[3:0], tseg2[2:0], sjw[1:0], threeSmp, expected cfgErr}
  localparam logic [10:0] CFG_VEC [10] = '{
    {4'd5,  3'd2, 2'd1, 1'b0, 1'b0},
    {4'd5,  3'd0, 2'd0, 1'b0, 1'b1},
    {4'd5,  3'd1, 2'd0, 1'b0, 1'b0},
    {4'd5,  3'd1, 2'd2, 1'b0, 1'b1},
    {4'd2,  3'd3, 2'd2, 1'b0, 1'b1},
    {4'd3,  3'd3, 2'd2, 1'b0, 1'b0},
    {4'd3,  3'd3, 2'd2, 1'b1, 1'b1},
    {4'd4,  3'd3, 2'd2, 1'b1, 1'b0},
    {4'd15, 3'd7, 2'd3, 1'b1, 1'b0},
    {4'd15, 3'd2, 2'd3, 1'b0, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic quantum();
    repeat (3) @(negedge clk);
    tqTick = 1'b1;
    @(negedge clk);
    tqTick = 1'b0;
  endtask

  task automatic quanta(input int n);
    for (int i = 0; i < n; i++) quantum();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 txPt", int'(txPt), 1);
    check("R1 sampleStb", int'(sampleStb), 0);
    check("R1 sampledBit", int'(sampledBit), 1);
    check("R1 phErr", int'(phErr), 0);

    for (int i = 0; i < 10; i++) begin
      {tseg1, tseg2, sjw, threeSmp} = CFG_VEC[i][10:1];
      #1;
      check($sformatf("R11 cfg vector %0d", i), int'(cfgErr), int'(CFG_VEC[i][0]));
    end
    @(negedge clk);
    tseg1 = 4'd5; tseg2 = 3'd2; sjw = 2'd1; threeSmp = 1'b0;

    // hard sync from idle
    busIdle = 1'b1; rxIn = 1'b1;
    quanta(3);
    rxIn = 1'b0;
    quantum();
    busIdle = 1'b0;
    check("R3 phErr after idle edge", int'(phErr), 0);
    check("R3 leaves sync quantum", int'(txPt), 0);
    quanta(5);
    check("R2 no strobe before seg1 end", int'(sampleStb), 0);
    quantum();
    check("R2 strobe at seg1 end", int'(sampleStb), 1);
    check("R2 sampled dominant", int'(sampledBit), 0);
    quantum();
    check("R2 strobe one quantum", int'(sampleStb), 0);
    quantum();
    check("R2 no txPt in seg2", int'(txPt), 0);
    quantum();
    check("R2 txPt at bit start", int'(txPt), 1);

    // large positive error: edge in quantum 4
    rxIn = 1'b1;
    quanta(4);
    rxIn = 1'b0;
    quantum();
    check("R4 phErr +4", int'(phErr), 4);
    quanta(2);
    check("R6 no strobe at normal point", int'(sampleStb), 0);
    quanta(2);
    check("R6 strobe after lengthening", int'(sampleStb), 1);
    quanta(3);
    check("R6 bit end after lengthening", int'(txPt), 1);

    // large negative error: edge in first seg2 quantum
    rxIn = 1'b1;
    quanta(7);
    check("R2 sampled recessive", int'(sampledBit), 1);
    rxIn = 1'b0;
    quantum();
    check("R4 phErr -3", int'(phErr), -3);
    check("R7 seg2 cut to sync", int'(txPt), 1);

    // small error: restart
    rxIn = 1'b1;
    quanta(2);
    rxIn = 1'b0;
    quantum();
    check("R4 phErr +2", int'(phErr), 2);
    quanta(4);
    check("R5 no strobe at old point", int'(sampleStb), 0);
    quanta(2);
    check("R5 strobe after restart", int'(sampleStb), 1);
    quanta(3);
    check("R5 bit end after restart", int'(txPt), 1);

    // once per bit
    rxIn = 1'b1;
    quanta(4);
    rxIn = 1'b0;
    quantum();
    rxIn = 1'b1;
    quantum();
    rxIn = 1'b0;
    quantum();
    check("R8 second edge phErr kept", int'(phErr), 4);
    check("R8 no strobe yet", int'(sampleStb), 0);
    quantum();
    check("R8 still no strobe", int'(sampleStb), 0);
    quantum();
    check("R8 strobe after one lengthening", int'(sampleStb), 1);
    quanta(3);
    check("R8 bit end", int'(txPt), 1);

    // own dominant transmission suppresses resync
    txDom = 1'b1;
    rxIn = 1'b1;
    quanta(3);
    rxIn = 1'b0;
    quantum();
    check("R9 phErr unchanged", int'(phErr), 4);
    quanta(3);
    check("R9 strobe at normal point", int'(sampleStb), 1);
    quanta(3);
    check("R9 bit end", int'(txPt), 1);

    // single sample, pattern 0,0,1
    rxIn = 1'b1; quanta(4);
    rxIn = 1'b0; quantum();
    rxIn = 1'b0; quantum();
    rxIn = 1'b1; quantum();
    check("R2 single sample takes last", int'(sampledBit), 1);
    quanta(3);

    // three-sample majority
    threeSmp = 1'b1;
    rxIn = 1'b1; quanta(4);
    rxIn = 1'b0; quantum();
    rxIn = 1'b0; quantum();
    rxIn = 1'b1; quantum();
    check("R10 majority 0,0,1", int'(sampledBit), 0);
    quanta(3);
    rxIn = 1'b1; quanta(4);
    rxIn = 1'b1; quantum();
    rxIn = 1'b1; quantum();
    rxIn = 1'b0; quantum();
    check("R10 majority 1,1,0", int'(sampledBit), 1);
    quanta(3);
    check("R10 bit end", int'(txPt), 1);

    // hard sync mid-bit while idle
    threeSmp = 1'b0; txDom = 1'b0; busIdle = 1'b1;
    rxIn = 1'b1; quanta(5);
    rxIn = 1'b0; quantum();
    busIdle = 1'b0;
    check("R3 phErr cleared", int'(phErr), 0);
    quanta(3);
    check("R3 no lengthened strobe", int'(sampleStb), 0);
    quanta(3);
    check("R3 strobe after restart", int'(sampleStb), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule